// File: doc/BRIEF.md
# Six-Button Gamepad Port Multiplexer

This block models one controller port as the host processor sees it. The host can write two byte-wide registers: a data register and a direction register. It can read back a byte that merges the data register with the state of a 12-button pad. Bit 6 of the data register acts as the select line toward the pad. Depending on its level, a read shows one half or the other of the button set.

When the six-button input is high, the block counts the select line's rising edges. On particular counts the read exposes the extra buttons (X, Y, Z, Mode) in place of the directions. When no data write arrives for a set number of clock ticks, the count returns to idle. The default is about 1.5 ms at 100 MHz.

Port pins that the direction register marks as outputs read back the data register. Bit 7 is always treated as an output. Reads are combinational and need no handshake. Writes are single-cycle strobes. The byte read is repeated in both halves of a 16-bit result.

Top module: `pad_port_mux`

## Requirements
- R1: After reset the data register, the direction register and the phase are all 0. With no button held, selector 0 then reads 16'h3333.
- R2: `btn_n` is active-low and is read without inversion, so a held button reads 0. Its bits are: Up 0, Down 1, Left 2, Right 3, B 4, C 5, A 6, Start 7, Z 8, Y 9, X 10, Mode 11.
- R3: The read byte starts as `data & (ctrl | 8'h80)`. The pad-derived bits 5..0 below are ORed onto it.
- R4: In normal reads with the select line (data bit 6) high, bits 5..0 are C, B, Right, Left, Down, Up.
- R5: In normal reads with the select line low, bits 5..0 are Start, A, 0, 0, Down, Up.
- R6: The phase starts at 0. It advances by one on a data write that takes bit 6 from 0 to 1, but only while `six_btn` is high. Writes that do not make that rise leave it unchanged. With PHASE_WRAP=0 it stays at 3; with PHASE_WRAP=1 it goes from 3 to 0. In phases 0 and 1, and in three-button mode, reads are normal.
- R7: In six-button mode at phase 2 with the select line low, bits 5..0 are Start, A, 0, 0, 0, 0.
- R8: In six-button mode at phase 3 with the select line high, bits 5..0 are C, B, Mode, X, Y, Z.
- R9: In six-button mode at phase 3 with the select line low, bits 5..0 are Start, A, 1, 1, 1, 1.
- R10: Every data write clears an idle counter. The phase returns to 0 at the TIMEOUT_TICKS-th rising edge after the last data write.
- R11: `rd_data` repeats the byte in both halves. Selector 0 gives the pad byte and selector 1 gives the direction register. A write to register 1 leaves the phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| six_btn | input | 1 | 1 selects six-button behaviour |
| btn_n | input | 12 | Pad buttons, active-low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 data, 1 direction |
| wr_data | input | 8 | Write byte |
| rd_sel | input | 1 | Read source: 0 pad byte, 1 direction |
| rd_data | output | 16 | Read value, byte repeated in both halves |

## Verification
Reads are combinational, so a change on `btn_n`, `six_btn` or `rd_sel` is visible in the same cycle. The bench samples 1 ns after driving these inputs, away from the clock edge. A register write, and any phase step it causes, shows on `rd_data` right after the rising edge that takes the strobe. The bench checks at the following falling edge. The idle return is checked on both sides of its boundary: once TIMEOUT_TICKS-1 edges after the last data write, when the phase must still hold, and once one edge later, when it must be 0. A repeat check confirms that a mid-window write restarts the count.

// File: rtl/pad_port_pkg.sv
package pad_port_pkg;
  typedef logic [1:0] phase_t;
  localparam int BTN_W   = 12;
  localparam int B_UP    = 0;
  localparam int B_DOWN  = 1;
  localparam int B_LEFT  = 2;
  localparam int B_RIGHT = 3;
  localparam int B_B     = 4;
  localparam int B_C     = 5;
  localparam int B_A     = 6;
  localparam int B_START = 7;
  localparam int B_Z     = 8;
  localparam int B_Y     = 9;
  localparam int B_X     = 10;
  localparam int B_MODE  = 11;
  localparam int SEL_BIT = 6;
  localparam phase_t PH_LAST = 2'd3;
endpackage

// File: rtl/pad_phase_track.sv
module pad_phase_track
  import pad_port_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 150000,
  parameter bit PHASE_WRAP    = 1'b0
)(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   six_en,
  input  logic   data_wr,
  input  logic   sel_old,
  input  logic   sel_new,
  output phase_t phase
);
  localparam int CNT_W = $clog2(TIMEOUT_TICKS) + 1;
  localparam logic [CNT_W-1:0] LIM = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] idle_cnt;
  logic             step;
  phase_t           phase_inc;

  assign step = data_wr && six_en && !sel_old && sel_new;

  generate
    if (PHASE_WRAP) begin : g_wrap
      assign phase_inc = phase + 2'd1;
    end else begin : g_sat
      assign phase_inc = (phase == PH_LAST) ? PH_LAST : phase + 2'd1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= '0;
      idle_cnt <= '0;
    end else if (data_wr) begin
      idle_cnt <= '0;
      if (step) phase <= phase_inc;
    end else if (idle_cnt == LIM) begin
      phase <= '0;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step && phase != PH_LAST |=> phase == $past(phase) + 2'd1); // R6
  AST_PHASE_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !step |=> $stable(phase)); // R6
  AST_PHASE_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr && idle_cnt == LIM |=> phase == '0); // R10
  AST_PHASE_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr && idle_cnt != LIM |=> $stable(phase)); // R10
endmodule

// File: rtl/pad_read_mux.sv
module pad_read_mux
  import pad_port_pkg::*;
(
  input  logic             six_en,
  input  phase_t           phase,
  input  logic [7:0]       data_q,
  input  logic [7:0]       ctrl_q,
  input  logic [BTN_W-1:0] btn_n,
  output logic [7:0]       val
);
  logic       sel;
  logic [7:0] base;
  logic [5:0] pad_bits;
  logic [1:0] sa;

  assign sel  = data_q[SEL_BIT];
  assign base = data_q & (ctrl_q | 8'h80);
  assign sa   = {btn_n[B_START], btn_n[B_A]};

  always_comb begin
    if (six_en && phase == 2'd2 && !sel)
      pad_bits = {sa, 4'b0000};
    else if (six_en && phase == PH_LAST && sel)
      pad_bits = {btn_n[B_C], btn_n[B_B], btn_n[B_MODE], btn_n[B_X],
                  btn_n[B_Y], btn_n[B_Z]};
    else if (six_en && phase == PH_LAST)
      pad_bits = {sa, 4'b1111};
    else if (sel)
      pad_bits = {btn_n[B_C], btn_n[B_B], btn_n[B_RIGHT], btn_n[B_LEFT],
                  btn_n[B_DOWN], btn_n[B_UP]};
    else
      pad_bits = {sa, 2'b00, btn_n[B_DOWN], btn_n[B_UP]};
  end

  assign val = base | {2'b00, pad_bits};
endmodule

// File: rtl/pad_port_mux.sv
module pad_port_mux
  import pad_port_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 150000,
  parameter bit PHASE_WRAP    = 1'b0
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        six_btn,
  input  logic [11:0] btn_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [7:0]  wr_data,
  input  logic        rd_sel,
  output logic [15:0] rd_data
);
  logic [7:0] data_q;
  logic [7:0] ctrl_q;
  logic [7:0] pad_val;
  logic [7:0] rd_byte;
  logic       data_wr;
  phase_t     phase;

  assign data_wr = wr_en && !wr_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) ctrl_q <= wr_data;
      else        data_q <= wr_data;
    end
  end

  pad_phase_track #(
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .PHASE_WRAP   (PHASE_WRAP)
  ) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .six_en (six_btn),
    .data_wr(data_wr),
    .sel_old(data_q[SEL_BIT]),
    .sel_new(wr_data[SEL_BIT]),
    .phase  (phase)
  );

  pad_read_mux u_mux (
    .six_en(six_btn),
    .phase (phase),
    .data_q(data_q),
    .ctrl_q(ctrl_q),
    .btn_n (btn_n),
    .val   (pad_val)
  );

  assign rd_byte = rd_sel ? ctrl_q : pad_val;
  assign rd_data = {rd_byte, rd_byte};

  AST_OUT_BIT7_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> rd_data[7] == data_q[7]); // R3
  AST_PH3_LOW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel && six_btn && phase == PH_LAST && !data_q[SEL_BIT]
      |-> rd_data[3:0] == 4'hF); // R9
  AST_PH2_LOW_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel && six_btn && phase == 2'd2 && !data_q[SEL_BIT] && ctrl_q[3:0] == 4'h0
      |-> rd_data[3:0] == 4'h0); // R7
  AST_CTRL_WR_KEEPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel |=> $stable(phase)); // R11
endmodule

// File: tb/sim_pad_port_mux.sv
module sim_pad_port_mux;
  localparam int TO = 40;

  logic        clk = 1'b0;
  logic        rst_n, six_btn, wr_en, wr_sel, rd_sel;
  logic [11:0] btn_n;
  logic [7:0]  wr_data;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit [1:0] mph;
  bit [7:0] mdata, mctrl;

  always #5 clk = ~clk;

  pad_port_mux #(.TIMEOUT_TICKS(TO), .PHASE_WRAP(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .six_btn(six_btn), .btn_n(btn_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  function automatic bit [7:0] expect_pad(bit m, bit [1:0] ph, bit [7:0] d,
                                          bit [7:0] c, bit [11:0] b);
    bit [7:0] v;
    bit th;
    th = d[6];
    v = d & (c | 8'h80);
    if (m && ph == 2 && !th)       v |= (b[7] * 32) + (b[6] * 16);
    else if (m && ph == 3 && th)   v |= (b[5] * 32) + (b[4] * 16) + (b[11] * 8)
                                        + (b[10] * 4) + (b[9] * 2) + b[8];
    else if (m && ph == 3)         v |= (b[7] * 32) + (b[6] * 16) + 15;
    else if (th)                   v |= b[5:0];
    else                           v |= (b[7] * 32) + (b[6] * 16) + (b[1] * 2) + b[0];
    return v;
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic check(string req, bit [15:0] exp);
    #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, rd_data, exp);
    end
  endtask

  task automatic chk_pad(string req);
    bit [7:0] e;
    rd_sel = 1'b0;
    e = expect_pad(six_btn, mph, mdata, mctrl, btn_n);
    check(req, {e, e});
  endtask

  task automatic wr(bit sel, bit [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    if (!sel) begin
      if (six_btn && !mdata[6] && d[6] && mph != 3) mph++;
      mdata = d;
    end else mctrl = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic go_idle();
    repeat (TO + 2) @(negedge clk);
    mph = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected finish");
    report();
    $finish;
  end

  initial begin
    bit [11:0] pats [8] = '{12'hFFF, 12'h000, 12'hA5C, 12'h5A3,
                            12'hF0F, 12'h0F0, 12'h3C6, 12'hC39};
    bit [7:0] cv [5] = '{8'h00, 8'h80, 8'hFF, 8'h0F, 8'hC3};
    bit [7:0] dv [4] = '{8'hFF, 8'hAA, 8'h55, 8'h3C};
    rst_n = 1'b0; six_btn = 1'b0; btn_n = 12'hFFF;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00; rd_sel = 1'b0;
    mph = 0; mdata = 0; mctrl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_sel = 1'b0; check("R1 reset pad", 16'h3333);
    rd_sel = 1'b1; check("R1 reset ctrl", 16'h0000);

    // R2 R4 R5 R6 R7 R8 R9: sweep modes, patterns and phases
    for (int m = 0; m < 2; m++) begin
      six_btn = m[0];
      wr(1'b1, 8'h40);
      for (int p = 0; p < 8; p++) begin
        btn_n = pats[p];
        go_idle();
        wr(1'b0, 8'h00); chk_pad("R5/R2 idle sel low");
        for (int k = 0; k < 4; k++) begin
          wr(1'b0, 8'h40); chk_pad("R4/R6/R8 sel high");
          wr(1'b0, 8'h00); chk_pad("R5/R7/R9 sel low");
        end
      end
    end

    // R3 R11: direction and data interplay, three-button mode
    six_btn = 1'b0; btn_n = 12'hA5C;
    for (int i = 0; i < 5; i++) begin
      wr(1'b1, cv[i]);
      rd_sel = 1'b1; check("R11 ctrl readback", {cv[i], cv[i]});
      for (int j = 0; j < 4; j++) begin
        wr(1'b0, dv[j]); chk_pad("R3 output pins");
      end
    end

    // R6: repeated high writes do not step
    six_btn = 1'b1; btn_n = 12'h5A3; wr(1'b1, 8'h40);
    go_idle();
    wr(1'b0, 8'h00); wr(1'b0, 8'h40); wr(1'b0, 8'h40);
    wr(1'b0, 8'h00); chk_pad("R6 no step without rise");
    wr(1'b0, 8'h40); wr(1'b0, 8'h00); chk_pad("R6 phase two R7");
    wr(1'b1, 8'h40); chk_pad("R11 ctrl write keeps phase");

    // R10: idle boundary
    go_idle();
    wr(1'b0, 8'h00); wr(1'b0, 8'h40); wr(1'b0, 8'h00);
    wr(1'b0, 8'h40); wr(1'b0, 8'h00); wr(1'b0, 8'h40);
    chk_pad("R10 phase three reached R8");
    repeat (TO - 1) @(negedge clk);
    chk_pad("R10 before timeout");
    @(negedge clk); mph = 0;
    chk_pad("R10 at timeout");

    // R10: mid-window write restarts the count
    go_idle();
    wr(1'b0, 8'h00); wr(1'b0, 8'h40); wr(1'b0, 8'h00);
    wr(1'b0, 8'h40); wr(1'b0, 8'h00); wr(1'b0, 8'h40);
    repeat (5) @(negedge clk);
    wr(1'b0, 8'h40);
    repeat (TO - 1) @(negedge clk);
    chk_pad("R10 restart holds");
    @(negedge clk); mph = 0;
    chk_pad("R10 restart clears");

    report();
    $finish;
  end
endmodule